// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a DDR2 or DDR3 SDRAM from power-on to normal operation. After a start pulse it walks through a fixed list of steps. Each step issues one command to a downstream command issuer, waits a programmed number of microseconds, or finishes the sequence. The memory-type input picks one of two step lists. The DDR2 list includes precharge-all, auto-refresh, DLL-reset and output-driver calibration steps. The DDR3 list includes an impedance calibration command.

Each command goes out on a simple port: a command code, a system address that selects the target mode-register bank, and two flag bits. The flags carry the DLL-reset state and the driver-calibration-default state. The valid strobe stays high until the issuer returns a one-cycle done pulse. The bank-select bits are placed at a bit offset computed from the column-count field, the row-count field, the address decode mode and the data-bus-width flag. These configuration inputs are captured when the sequence starts.

When the list ends, the block pulses a refresh-load strobe with the refresh-rate value captured at start, and raises ready. Ready stays high until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ready, cmd_valid and refresh_load are low.
- R2: A start pulse in idle begins the sequence and captures the configuration inputs and refresh_cfg. A start pulse while the sequence runs, or after ready, has no effect on the commands issued.
- R3: The bank offset is col_sel + 9, plus row_sel + 11 when decode is sequential, plus 1 when half_width is 1 or 2 when it is 0. Every mode-register-set command carries address = bank << offset, and commands without a bank carry address 0.
- R4: DDR2 (ddr3_mode = 0) order and flags:
  - NOP, wait 200 us, NOP, precharge-all;
  - EMRS to bank 2, then bank 3, then bank 1;
  - MRS, precharge-all, refresh, refresh, all four with the DLL flag set;
  - MRS with the DLL flag clear;
  - EMRS to bank 1 with the calibration-default flag set, then EMRS to bank 1 with it clear;
  - normal, dummy write.
- R5: DDR3 (ddr3_mode = 1) order: NOP, wait 500 us, NOP, EMRS banks 2, 3, 1, MRS, wait 50 us, calibration, normal, dummy write. Both flags stay clear throughout.
- R6: cmd_valid and the command fields stay unchanged until cmd_done is seen. The next command is presented with exactly one idle cycle of cmd_valid low between commands when no wait step lies between them.
- R7: A wait of U us holds cmd_valid low for U*CLK_PER_US + 2 cycles between the surrounding commands: the counted delay plus two step-decode cycles.
- R8: The cmd_code encoding is 0 NOP, 1 normal, 2 precharge-all, 3 MRS, 4 refresh, 5 EMRS, 6 calibration, 7 dummy write.
- R9: Interleaved decode (interleave = 1) leaves out the row term only when the INTERLEAVE_OK parameter is 1. Otherwise decode is treated as sequential.
- R10: After the dummy write completes, refresh_load pulses for exactly one cycle with refresh_value equal to the captured refresh_cfg, and ready rises in the same cycle. Ready then stays high and no further command is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the sequence when idle |
| ddr3_mode | input | 1 | 0 selects the DDR2 list, 1 selects the DDR3 list |
| col_sel | input | COL_W | Column-count field |
| row_sel | input | ROW_W | Row-count field |
| interleave | input | 1 | Interleaved bank decode request |
| half_width | input | 1 | Data-bus-width flag |
| refresh_cfg | input | RW | Refresh-rate value to load at the end |
| cmd_valid | output | 1 | Command strobe, held until done |
| cmd_code | output | 3 | Command code (R8) |
| cmd_addr | output | AW | Address carrying the bank-select bits |
| cmd_dll_reset | output | 1 | DLL-reset flag state |
| cmd_ocd_default | output | 1 | Driver-calibration-default flag state |
| cmd_done | input | 1 | One-cycle completion from the command issuer |
| refresh_load | output | 1 | One-cycle load strobe for the refresh rate |
| refresh_value | output | RW | Refresh-rate value |
| ready | output | 1 | Initialization complete |

## Verification
The assertions check on every cycle that a presented command holds still until its done arrives, that the delay counter steps down by one each cycle, that the captured bank offset stays in its legal range, and that ready is sticky with a single load strobe and no command activity after it. Whether the right commands appear in the right order, with the right banks and flags, and whether each wait lasts exactly as long as programmed, can only be shown by the bench. Its scoreboard compares every issued command and the idle gap before it against lists built from the requirements. The bench runs both memory types, several offset configurations and both settings of the interleave parameter.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM initialization sequencer.
// Assumes: command codes fit in 3 bits; bank offsets fit in OFS_W bits.
package sdram_init_pkg;

    localparam int OFS_W = 5;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_NORMAL = 3'd1,
        CMD_PALL   = 3'd2,
        CMD_MRS    = 3'd3,
        CMD_REF    = 3'd4,
        CMD_EMRS   = 3'd5,
        CMD_CAL    = 3'd6,
        CMD_WRITE  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_WAIT = 2'd1,
        K_LOAD = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        W_NONE = 2'd0,
        W_PWR2 = 2'd1,
        W_PWR3 = 2'd2,
        W_DLL  = 2'd3
    } wait_e;

    typedef struct packed {
        kind_e      kind;
        cmd_e       code;
        logic [1:0] bank;
        logic       dll;
        logic       ocd;
        wait_e      wsel;
    } step_t;

endpackage

// File: rtl/bank_offset_calc.sv
// Computes the bit position of the bank-select field in the system address.
// Assumes: fields are static while sampled; the result is captured by the caller.
module bank_offset_calc
    import sdram_init_pkg::*;
#(
    parameter int COL_W         = 2,
    parameter int ROW_W         = 2,
    parameter bit INTERLEAVE_OK = 1'b1
) (
    input  logic [COL_W-1:0] col_sel,
    input  logic [ROW_W-1:0] row_sel,
    input  logic             interleave,
    input  logic             half_width,
    output logic [OFS_W-1:0] offset
);
    logic seq_decode;

    // Interleave only counts when the platform parameter permits it.
    generate
        if (INTERLEAVE_OK) begin : g_il
            assign seq_decode = ~interleave;
        end else begin : g_seq
            assign seq_decode = 1'b1;
        end
    endgenerate

    // Sum of column term, optional row term and bus-width term.
    always_comb begin
        offset = OFS_W'(col_sel) + OFS_W'(9);
        if (seq_decode) begin
            offset = offset + OFS_W'(row_sel) + OFS_W'(11);
        end
        offset = offset + (half_width ? OFS_W'(1) : OFS_W'(2));
    end
endmodule

// File: rtl/init_step_table.sv
// Maps a step index to the step descriptor for the selected memory type.
// Assumes: indices past the end of a list read as the final load step.
module init_step_table
    import sdram_init_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             ddr3,
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    // Builds a command step.
    function automatic step_t mk_cmd(cmd_e c, logic [1:0] b, logic d, logic o);
        step_t s;
        s.kind = K_CMD; s.code = c; s.bank = b; s.dll = d; s.ocd = o; s.wsel = W_NONE;
        return s;
    endfunction

    // Builds a wait step.
    function automatic step_t mk_wait(wait_e w);
        step_t s;
        s.kind = K_WAIT; s.code = CMD_NOP; s.bank = 2'd0; s.dll = 1'b0; s.ocd = 1'b0; s.wsel = w;
        return s;
    endfunction

    // Builds the final refresh-load step.
    function automatic step_t mk_load();
        step_t s;
        s.kind = K_LOAD; s.code = CMD_NOP; s.bank = 2'd0; s.dll = 1'b0; s.ocd = 1'b0; s.wsel = W_NONE;
        return s;
    endfunction

    // Step list lookup for both memory types.
    always_comb begin
        step = mk_load();
        if (!ddr3) begin
            case (idx)
                IDX_W'(0):  step = mk_cmd(CMD_NOP,    2'd0, 1'b0, 1'b0);
                IDX_W'(1):  step = mk_wait(W_PWR2);
                IDX_W'(2):  step = mk_cmd(CMD_NOP,    2'd0, 1'b0, 1'b0);
                IDX_W'(3):  step = mk_cmd(CMD_PALL,   2'd0, 1'b0, 1'b0);
                IDX_W'(4):  step = mk_cmd(CMD_EMRS,   2'd2, 1'b0, 1'b0);
                IDX_W'(5):  step = mk_cmd(CMD_EMRS,   2'd3, 1'b0, 1'b0);
                IDX_W'(6):  step = mk_cmd(CMD_EMRS,   2'd1, 1'b0, 1'b0);
                IDX_W'(7):  step = mk_cmd(CMD_MRS,    2'd0, 1'b1, 1'b0);
                IDX_W'(8):  step = mk_cmd(CMD_PALL,   2'd0, 1'b1, 1'b0);
                IDX_W'(9):  step = mk_cmd(CMD_REF,    2'd0, 1'b1, 1'b0);
                IDX_W'(10): step = mk_cmd(CMD_REF,    2'd0, 1'b1, 1'b0);
                IDX_W'(11): step = mk_cmd(CMD_MRS,    2'd0, 1'b0, 1'b0);
                IDX_W'(12): step = mk_cmd(CMD_EMRS,   2'd1, 1'b0, 1'b1);
                IDX_W'(13): step = mk_cmd(CMD_EMRS,   2'd1, 1'b0, 1'b0);
                IDX_W'(14): step = mk_cmd(CMD_NORMAL, 2'd0, 1'b0, 1'b0);
                IDX_W'(15): step = mk_cmd(CMD_WRITE,  2'd0, 1'b0, 1'b0);
                default:    step = mk_load();
            endcase
        end else begin
            case (idx)
                IDX_W'(0):  step = mk_cmd(CMD_NOP,    2'd0, 1'b0, 1'b0);
                IDX_W'(1):  step = mk_wait(W_PWR3);
                IDX_W'(2):  step = mk_cmd(CMD_NOP,    2'd0, 1'b0, 1'b0);
                IDX_W'(3):  step = mk_cmd(CMD_EMRS,   2'd2, 1'b0, 1'b0);
                IDX_W'(4):  step = mk_cmd(CMD_EMRS,   2'd3, 1'b0, 1'b0);
                IDX_W'(5):  step = mk_cmd(CMD_EMRS,   2'd1, 1'b0, 1'b0);
                IDX_W'(6):  step = mk_cmd(CMD_MRS,    2'd0, 1'b0, 1'b0);
                IDX_W'(7):  step = mk_wait(W_DLL);
                IDX_W'(8):  step = mk_cmd(CMD_CAL,    2'd0, 1'b0, 1'b0);
                IDX_W'(9):  step = mk_cmd(CMD_NORMAL, 2'd0, 1'b0, 1'b0);
                IDX_W'(10): step = mk_cmd(CMD_WRITE,  2'd0, 1'b0, 1'b0);
                default:    step = mk_load();
            endcase
        end
    end
endmodule

// File: rtl/delay_timer.sv
// Down-counter that expires after exactly the loaded number of cycles.
// Assumes: load_val >= 1; load only while not busy.
module delay_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic          busy;
    logic [TW-1:0] cnt;

    assign expire = busy && (cnt == '0);

    // Loads, counts down and stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= load_val - TW'(1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - TW'(1);
        end
    end

    // R7: the count steps down by exactly one per cycle.
    assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0 && !load) |=> (busy && cnt == $past(cnt) - TW'(1)));

    // R7: expiry ends the wait.
    assert_expire_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> !busy);
endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up initialization sequencer top.
// Walks the DDR2 or DDR3 step list, issues commands with a held valid
// strobe, times the waits and ends with a refresh-rate load and ready.
// Assumes: cmd_done is a one-cycle pulse given only while cmd_valid is high.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int AW            = 32,
    parameter int RW            = 12,
    parameter int COL_W         = 2,
    parameter int ROW_W         = 2,
    parameter bit INTERLEAVE_OK = 1'b1,
    parameter int CLK_PER_US    = 200,
    parameter int PWR_DDR2_US   = 200,
    parameter int PWR_DDR3_US   = 500,
    parameter int DLL_WAIT_US   = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ddr3_mode,
    input  logic [COL_W-1:0] col_sel,
    input  logic [ROW_W-1:0] row_sel,
    input  logic             interleave,
    input  logic             half_width,
    input  logic [RW-1:0]    refresh_cfg,
    output logic             cmd_valid,
    output logic [2:0]       cmd_code,
    output logic [AW-1:0]    cmd_addr,
    output logic             cmd_dll_reset,
    output logic             cmd_ocd_default,
    input  logic             cmd_done,
    output logic             refresh_load,
    output logic [RW-1:0]    refresh_value,
    output logic             ready
);
    localparam int IDX_W   = 5;
    localparam int CYC_P2  = PWR_DDR2_US * CLK_PER_US;
    localparam int CYC_P3  = PWR_DDR3_US * CLK_PER_US;
    localparam int CYC_DLL = DLL_WAIT_US * CLK_PER_US;
    localparam int CYC_MAX = (CYC_P2 > CYC_P3) ? ((CYC_P2 > CYC_DLL) ? CYC_P2 : CYC_DLL)
                                               : ((CYC_P3 > CYC_DLL) ? CYC_P3 : CYC_DLL);
    localparam int TW      = $clog2(CYC_MAX + 1);
    localparam logic [OFS_W-1:0] OFS_MIN = OFS_W'(9);
    localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'((1 << COL_W) - 1 + 9 + (1 << ROW_W) - 1 + 11 + 2);

    typedef enum logic [2:0] {S_IDLE, S_STEP, S_ISSUE, S_DELAY, S_DONE} state_e;

    state_e           state;
    logic [IDX_W-1:0] idx;
    logic             ddr3_q;
    logic [OFS_W-1:0] off_q;
    logic [OFS_W-1:0] off_calc;
    logic [RW-1:0]    refresh_q;
    step_t            cur;
    logic             t_load;
    logic [TW-1:0]    t_val;
    logic             t_expire;

    bank_offset_calc #(
        .COL_W(COL_W), .ROW_W(ROW_W), .INTERLEAVE_OK(INTERLEAVE_OK)
    ) u_ofs (
        .col_sel(col_sel), .row_sel(row_sel), .interleave(interleave),
        .half_width(half_width), .offset(off_calc)
    );

    init_step_table #(.IDX_W(IDX_W)) u_tbl (
        .ddr3(ddr3_q), .idx(idx), .step(cur)
    );

    // Selects the wait length for the current wait step.
    always_comb begin
        case (cur.wsel)
            W_PWR2:  t_val = TW'(CYC_P2);
            W_PWR3:  t_val = TW'(CYC_P3);
            W_DLL:   t_val = TW'(CYC_DLL);
            default: t_val = TW'(1);
        endcase
        t_load = (state == S_STEP) && (cur.kind == K_WAIT);
    end

    delay_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expire(t_expire)
    );

    // Main sequencer: capture, decode steps, hold commands, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= S_IDLE;
            idx             <= '0;
            ddr3_q          <= 1'b0;
            off_q           <= OFS_MIN;
            refresh_q       <= '0;
            cmd_valid       <= 1'b0;
            cmd_code        <= 3'd0;
            cmd_addr        <= '0;
            cmd_dll_reset   <= 1'b0;
            cmd_ocd_default <= 1'b0;
            refresh_load    <= 1'b0;
            refresh_value   <= '0;
            ready           <= 1'b0;
        end else begin
            refresh_load <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state     <= S_STEP;
                        idx       <= '0;
                        ddr3_q    <= ddr3_mode;
                        off_q     <= off_calc;
                        refresh_q <= refresh_cfg;
                    end
                end
                S_STEP: begin
                    case (cur.kind)
                        K_CMD: begin
                            cmd_valid       <= 1'b1;
                            cmd_code        <= cur.code;
                            cmd_addr        <= AW'(cur.bank) << off_q;
                            cmd_dll_reset   <= cur.dll;
                            cmd_ocd_default <= cur.ocd;
                            state           <= S_ISSUE;
                        end
                        K_WAIT: state <= S_DELAY;
                        default: begin
                            refresh_load  <= 1'b1;
                            refresh_value <= refresh_q;
                            ready         <= 1'b1;
                            state         <= S_DONE;
                        end
                    endcase
                end
                S_ISSUE: begin
                    if (cmd_done) begin
                        cmd_valid <= 1'b0;
                        idx       <= idx + IDX_W'(1);
                        state     <= S_STEP;
                    end
                end
                S_DELAY: begin
                    if (t_expire) begin
                        idx   <= idx + IDX_W'(1);
                        state <= S_STEP;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: a presented command holds still until done.
    assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_addr)
                                      && $stable(cmd_dll_reset) && $stable(cmd_ocd_default)));

    // R6: done drops the strobe for at least one cycle.
    assert_gap_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done) |=> !cmd_valid);

    // R3: the captured offset stays in its legal range once running.
    assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (off_q >= OFS_MIN && off_q <= OFS_MAX));

    // R10: ready is sticky.
    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R10: the load strobe is a single cycle coinciding with ready rising.
    assert_load_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_load |-> ($rose(ready) ##1 !refresh_load));

    // R10: no command activity once ready.
    assert_quiet_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !cmd_valid);
endmodule

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
    localparam int CPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ddr3_mode = 1'b0;
    logic [1:0]  col_sel = 2'd0;
    logic [1:0]  row_sel = 2'd0;
    logic        interleave = 1'b0;
    logic        half_width = 1'b0;
    logic [11:0] refresh_cfg = 12'd0;
    logic        cmd_valid, cmd_dll_reset, cmd_ocd_default, refresh_load, ready;
    logic [2:0]  cmd_code;
    logic [31:0] cmd_addr;
    logic [11:0] refresh_value;
    logic        cmd_done = 1'b0;

    logic        v2, dll2, ocd2, rl2, rdy2;
    logic [2:0]  code2;
    logic [31:0] addr2;
    logic [11:0] rv2;
    logic        done2;

    always #2.5 clk = ~clk;

    sdram_init_seq #(.CLK_PER_US(CPU), .INTERLEAVE_OK(1'b1)) u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ddr3_mode(ddr3_mode),
        .col_sel(col_sel), .row_sel(row_sel), .interleave(interleave),
        .half_width(half_width), .refresh_cfg(refresh_cfg),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .cmd_dll_reset(cmd_dll_reset), .cmd_ocd_default(cmd_ocd_default),
        .cmd_done(cmd_done), .refresh_load(refresh_load),
        .refresh_value(refresh_value), .ready(ready)
    );

    sdram_init_seq #(.CLK_PER_US(CPU), .INTERLEAVE_OK(1'b0)) u_sdram_init_seq_seqonly (
        .clk(clk), .rst_n(rst_n), .start(start), .ddr3_mode(ddr3_mode),
        .col_sel(col_sel), .row_sel(row_sel), .interleave(interleave),
        .half_width(half_width), .refresh_cfg(refresh_cfg),
        .cmd_valid(v2), .cmd_code(code2), .cmd_addr(addr2),
        .cmd_dll_reset(dll2), .cmd_ocd_default(ocd2),
        .cmd_done(done2), .refresh_load(rl2),
        .refresh_value(rv2), .ready(rdy2)
    );
    assign done2 = v2;

    typedef struct {
        int          code;
        logic [31:0] addr;
        bit          dll;
        bit          ocd;
        int          gap;
    } exp_t;

    exp_t expq[$];
    int checks = 0;
    int errors = 0;
    int gap_cnt = 0;
    int rises = 0;
    int lat = 0;
    int lat_cnt = 0;
    bit prev_valid = 1'b0;
    bit got_emrs2 = 1'b0;
    logic [31:0] first_emrs2 = 32'd0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: push one expected command onto the scoreboard.
    task automatic push(input int code, input int bank, input bit dll, input bit ocd,
                        input int gap, input int off);
        exp_t e;
        e.code = code; e.addr = 32'(bank) << off; e.dll = dll; e.ocd = ocd; e.gap = gap;
        expq.push_back(e);
    endtask

    // R4: DDR2 expected list.
    task automatic push_ddr2(input int off);
        push(0, 0, 0, 0, 0, off);
        push(0, 0, 0, 0, 200 * CPU + 2, off);
        push(2, 0, 0, 0, 1, off);
        push(5, 2, 0, 0, 1, off);
        push(5, 3, 0, 0, 1, off);
        push(5, 1, 0, 0, 1, off);
        push(3, 0, 1, 0, 1, off);
        push(2, 0, 1, 0, 1, off);
        push(4, 0, 1, 0, 1, off);
        push(4, 0, 1, 0, 1, off);
        push(3, 0, 0, 0, 1, off);
        push(5, 1, 0, 1, 1, off);
        push(5, 1, 0, 0, 1, off);
        push(1, 0, 0, 0, 1, off);
        push(7, 0, 0, 0, 1, off);
    endtask

    // R5: DDR3 expected list.
    task automatic push_ddr3(input int off);
        push(0, 0, 0, 0, 0, off);
        push(0, 0, 0, 0, 500 * CPU + 2, off);
        push(5, 2, 0, 0, 1, off);
        push(5, 3, 0, 0, 1, off);
        push(5, 1, 0, 0, 1, off);
        push(3, 0, 0, 0, 1, off);
        push(6, 0, 0, 0, 50 * CPU + 2, off);
        push(1, 0, 0, 0, 1, off);
        push(7, 0, 0, 0, 1, off);
    endtask

    // Command issuer model with rotating done latency.
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_done = 1'b0; lat_cnt = 0;
        end else if (cmd_valid && !cmd_done) begin
            if (lat_cnt >= lat) begin
                cmd_done = 1'b1; lat_cnt = 0; lat = (lat + 1) % 4;
            end else begin
                lat_cnt++;
            end
        end else begin
            cmd_done = 1'b0;
        end
    end

    // Monitor: pop and compare on each new command; measure idle gaps.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_valid = 1'b0; gap_cnt = 0; got_emrs2 = 1'b0;
        end else begin
            if (cmd_valid && !prev_valid) begin
                rises++;
                if (expq.size() == 0) begin
                    check(1'b0, "R2/R10", "unexpected command", cmd_code, -1);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(cmd_code == 3'(e.code), "R8/R4/R5", "cmd_code", cmd_code, e.code);
                    check(cmd_addr == e.addr, "R3", "cmd_addr", cmd_addr, e.addr);
                    check(cmd_dll_reset == e.dll, "R4", "dll flag", cmd_dll_reset, e.dll);
                    check(cmd_ocd_default == e.ocd, "R4", "ocd flag", cmd_ocd_default, e.ocd);
                    if (e.gap > 1)
                        check(gap_cnt == e.gap, "R7", "wait gap", gap_cnt, e.gap);
                    else if (e.gap == 1)
                        check(gap_cnt == 1, "R6", "command gap", gap_cnt, 1);
                end
            end
            if (cmd_valid) gap_cnt = 0; else gap_cnt++;
            prev_valid = cmd_valid;
            if (v2 && code2 == 3'd5 && !got_emrs2) begin
                got_emrs2 = 1'b1; first_emrs2 = addr2;
            end
        end
    end

    // Full scenario: reset, configure, start, finish, post-ready checks.
    task automatic run_seq(input bit d3, input int c, input int r, input bit il,
                           input bit hw, input int rfsh, input int off);
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!ready && !cmd_valid && !refresh_load, "R1", "outputs in reset",
              {ready, cmd_valid, refresh_load}, 0);
        ddr3_mode = d3; col_sel = 2'(c); row_sel = 2'(r); interleave = il;
        half_width = hw; refresh_cfg = 12'(rfsh);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ready && !cmd_valid && !refresh_load, "R1", "outputs after reset",
              {ready, cmd_valid, refresh_load}, 0);
        if (d3) push_ddr3(off); else push_ddr2(off);
        start = 1'b1; @(negedge clk); start = 1'b0;
        // R2: captured config must survive input changes and a stray start.
        refresh_cfg = 12'hABC; col_sel = ~col_sel;
        repeat (30) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        n = 0;
        while (!ready && n < 20000) begin @(negedge clk); n++; end
        check(n < 20000, "R10", "ready reached", n, 20000);
        check(refresh_load == 1'b1, "R10", "refresh_load pulse", refresh_load, 1);
        check(refresh_value == 12'(rfsh), "R2/R10", "refresh_value", refresh_value, rfsh);
        check(expq.size() == 0, "R4/R5", "commands left", expq.size(), 0);
        @(negedge clk);
        check(refresh_load == 1'b0, "R10", "single pulse", refresh_load, 0);
        check(ready == 1'b1, "R10", "ready sticky", ready, 1);
        n = rises;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        check(rises == n && ready, "R2", "start after ready ignored", rises - n, 0);
        expq.delete();
    endtask

    initial begin
        // DDR2 sequential: 1+9 + 2+11 + 2 = 25
        run_seq(1'b0, 1, 2, 1'b0, 1'b0, 12'h3A5, 25);
        // DDR3 interleaved honoured: 3+9 + 1 = 13
        run_seq(1'b1, 3, 0, 1'b1, 1'b1, 12'h0F1, 13);
        // R9: the instance without interleave support uses 3+9 + 0+11 + 1 = 24
        check(got_emrs2 && first_emrs2 == (32'd2 << 24), "R9", "seq-only EMRS addr",
              first_emrs2, 32'd2 << 24);
        // DDR2 interleaved with full bus: 0+9 + 2 = 11
        run_seq(1'b0, 0, 3, 1'b1, 1'b0, 12'h7FF, 11);
        // DDR3 sequential, largest offset: 3+9 + 3+11 + 2 = 28
        run_seq(1'b1, 3, 3, 1'b0, 1'b0, 12'h001, 28);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule